// File: doc/BRIEF.md
# Reference clock frequency meter

The block measures how fast an external clock runs by counting its rising edges during a fixed gate. The gate comes from a local reference clock: a timer counts a parameterised number of reference cycles, and the default value equals one second at 100 MHz. When a gate closes, the external-domain counter hands its total across to the reference domain and starts again from zero. The reference domain always holds the latest complete count.

A host reads the count over a byte-oriented serial link. Here the link is reduced to a frame select, a strobe for each byte slot, the byte received in that slot, and a registered byte to return. The opcode 0xFE in the first slot selects a read. The strobe of the second slot is a dummy byte, and it freezes the current count in a readout register. The next four slots shift that frozen value out, most significant byte first. A gate that completes during the read cannot change the bytes that remain.

Top module: `clk_freq_meter`

## Requirements
- R1: Once the first gate has finished, every result equals the number of rising edges of `meas_clk` between two consecutive gate ends. A gate is GATE_CYCLES cycles of `ref_clk`. For example, with a measured clock twice as fast as the reference the result is 2×GATE_CYCLES.
- R2: The result is refreshed once per gate. After the measured frequency changes, the next full gate brings the new count.
- R3: The result is a whole count that crosses into the reference domain. Reads taken at different times while the frequency is steady return the same value.
- R4: A snapshot taken before the first gate has finished returns zero in all four bytes.
- R5: A frame starts with `host_sel` high. Its first strobed byte is the opcode. When the opcode is 0xFE, the strobe of the second slot copies the result into the readout register, and after that strobe `host_dout` carries bits 31:24.
- R6: The strobes of slots 3, 4 and 5 of a read frame return bits 23:16, 15:8 and 7:0 of the frozen value, in that order. `host_dout` changes only on the clock edge that registers a strobe.
- R7: A new result that arrives after the snapshot does not change the bytes still to be shifted out in that frame.
- R8: Strobes after the fourth data byte return 0x00.
- R9: An opcode other than 0xFE takes no snapshot. `host_dout` then stays 0x00 for the whole frame.
- R10: Taking `host_sel` low ends the frame. `host_dout` reads 0x00 one clock later, and the next strobed byte is decoded as an opcode.
- R11: After reset `host_dout` is 0x00 and the held result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; the gate and host side run on it |
| ref_rst_n | input | 1 | Asynchronous active-low reset, reference domain |
| meas_clk | input | 1 | External clock being measured |
| meas_rst_n | input | 1 | Asynchronous active-low reset, measured domain |
| host_sel | input | 1 | High for the duration of a host frame |
| host_stb | input | 1 | One-cycle strobe per byte slot |
| host_din | input | 8 | Byte received in the strobed slot |
| host_dout | output | 8 | Byte returned for the next slot |

## Verification
The hardest condition to reach from the ports is a result update that lands between the snapshot and the last byte shifted out, because the host cannot see when a gate closes. The stimulus takes the snapshot while the count is steady. It then changes the period of the measured clock and keeps the frame open for several gates before it strobes the remaining bytes, so that at least one new and different result is known to have arrived. The measured clock is generated at exact integer ratios to the reference, with its edges offset from the reference edges, so each complete gate has one exact expected count and no race at the clock edges.

// File: rtl/fm_pkg.sv
package fm_pkg;

    localparam logic [7:0] OPC_READ = 8'hFE;
    localparam int unsigned BYTE_W  = 8;

    typedef enum logic [1:0] {
        SLOT_OPC   = 2'd0,
        SLOT_SNAP  = 2'd1,
        SLOT_SHIFT = 2'd2
    } slot_e;

endpackage

// File: rtl/fm_gate_timer.sv
module fm_gate_timer #(
    parameter int unsigned GATE_CYCLES = 100_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic gate_tgl_o
);
    localparam int unsigned CW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(GATE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tgl;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.tgl = ~st_q.tgl;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign gate_tgl_o = st_q.tgl;

    // R1: the gate counter never passes its last cycle
    p_gate_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= LAST);

    // R1: a gate edge is always followed by a fresh window starting at zero
    p_gate_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.tgl != $past(st_q.tgl)) |-> (st_q.cnt == '0));

endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             gate_tgl_i,
    output logic [CNT_W-1:0] hold_o,
    output logic             ack_tgl_o
);
    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             ack;
    } meas_st_t;

    meas_st_t st_d, st_q;
    logic capture;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], gate_tgl_i};
        capture   = st_q.sync[2] ^ st_q.sync[1];
        cnt_next  = (&st_q.cnt) ? st_q.cnt : st_q.cnt + CNT_W'(1);
        if (capture) begin
            st_d.hold = cnt_next;
            st_d.cnt  = '0;
            st_d.ack  = ~st_q.ack;
        end else begin
            st_d.cnt  = cnt_next;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign hold_o    = st_q.hold;
    assign ack_tgl_o = st_q.ack;

    // R3: the held total moves only together with the handshake toggle
    p_hold_with_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.hold != $past(st_q.hold)) |-> (st_q.ack != $past(st_q.ack)));

    // R1: every hand-off starts a new count
    p_count_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ack != $past(st_q.ack)) |-> (st_q.cnt == '0));

endmodule

// File: rtl/fm_result_sync.sv
module fm_result_sync #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ack_tgl_i,
    input  logic [CNT_W-1:0] hold_i,
    output logic [CNT_W-1:0] result_o
);
    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] res;
    } res_st_t;

    res_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], ack_tgl_i};
        if (st_q.sync[2] ^ st_q.sync[1]) st_d.res = hold_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign result_o = st_q.res;

    // R2: the result is replaced only after a handshake edge has arrived
    p_result_on_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.res != $past(st_q.res)) |-> ($past(st_q.sync[2]) != $past(st_q.sync[1])));

endmodule

// File: rtl/fm_readout.sv
module fm_readout
    import fm_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              stb_i,
    input  logic [BYTE_W-1:0] din_i,
    input  logic [CNT_W-1:0]  result_i,
    output logic [BYTE_W-1:0] dout_o
);
    typedef struct packed {
        slot_e             slot;
        logic              rd;
        logic [CNT_W-1:0]  shreg;
        logic [BYTE_W-1:0] dout;
    } ro_st_t;

    ro_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sel_i) begin
            st_d.slot  = SLOT_OPC;
            st_d.rd    = 1'b0;
            st_d.shreg = '0;
            st_d.dout  = '0;
        end else if (stb_i) begin
            case (st_q.slot)
                SLOT_OPC: begin
                    st_d.rd   = (din_i == OPC_READ);
                    st_d.dout = '0;
                    st_d.slot = SLOT_SNAP;
                end
                SLOT_SNAP: begin
                    if (st_q.rd) begin
                        st_d.dout  = result_i[CNT_W-1 -: BYTE_W];
                        st_d.shreg = result_i << BYTE_W;
                    end
                    st_d.slot = SLOT_SHIFT;
                end
                default: begin
                    if (st_q.rd) begin
                        st_d.dout  = st_q.shreg[CNT_W-1 -: BYTE_W];
                        st_d.shreg = st_q.shreg << BYTE_W;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dout_o = st_q.dout;

    // R9: without a read opcode the return byte stays zero
    p_quiet_unless_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.rd |-> (st_q.dout == '0));

    // R7: frozen value and output hold between strobes inside a frame
    p_hold_between_strobes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && !stb_i) |=> ($stable(st_q.dout) && $stable(st_q.shreg)));

    // R10: deselect clears the output and rewinds to the opcode slot
    p_deselect_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |=> ((st_q.dout == '0) && (st_q.slot == SLOT_OPC)));

endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
    parameter int unsigned GATE_CYCLES = 100_000_000,
    parameter int unsigned CNT_W       = 32
) (
    input  logic       ref_clk,
    input  logic       ref_rst_n,
    input  logic       meas_clk,
    input  logic       meas_rst_n,
    input  logic       host_sel,
    input  logic       host_stb,
    input  logic [7:0] host_din,
    output logic [7:0] host_dout
);
    logic             gate_tgl;
    logic             ack_tgl;
    logic [CNT_W-1:0] hold_cnt;
    logic [CNT_W-1:0] result;

    fm_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
        .clk_i      (ref_clk),
        .rst_ni     (ref_rst_n),
        .gate_tgl_o (gate_tgl)
    );

    fm_edge_counter #(.CNT_W(CNT_W)) u_count (
        .clk_i      (meas_clk),
        .rst_ni     (meas_rst_n),
        .gate_tgl_i (gate_tgl),
        .hold_o     (hold_cnt),
        .ack_tgl_o  (ack_tgl)
    );

    fm_result_sync #(.CNT_W(CNT_W)) u_sync (
        .clk_i     (ref_clk),
        .rst_ni    (ref_rst_n),
        .ack_tgl_i (ack_tgl),
        .hold_i    (hold_cnt),
        .result_o  (result)
    );

    fm_readout #(.CNT_W(CNT_W)) u_read (
        .clk_i    (ref_clk),
        .rst_ni   (ref_rst_n),
        .sel_i    (host_sel),
        .stb_i    (host_stb),
        .din_i    (host_din),
        .result_i (result),
        .dout_o   (host_dout)
    );

endmodule

// File: tb/sim_clk_freq_meter.sv
`timescale 1ns/1ps
module sim_clk_freq_meter;
    localparam int CLK_PERIOD = 20;
    localparam int GATE       = 50;

    logic       ref_clk = 1'b0;
    logic       meas_clk = 1'b0;
    logic       ref_rst_n, meas_rst_n;
    logic       host_sel, host_stb;
    logic [7:0] host_din;
    logic [7:0] host_dout;

    int   total = 0;
    int   bad = 0;
    int   meas_period = 10;
    int   meas_hp;
    bit   model_on = 1'b0;
    logic [7:0] exp_dout = 8'h00;

    clk_freq_meter #(.GATE_CYCLES(GATE), .CNT_W(32)) u0 (
        .ref_clk    (ref_clk),
        .ref_rst_n  (ref_rst_n),
        .meas_clk   (meas_clk),
        .meas_rst_n (meas_rst_n),
        .host_sel   (host_sel),
        .host_stb   (host_stb),
        .host_din   (host_din),
        .host_dout  (host_dout)
    );

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    // measured clock: even periods, rising edges on odd times, never on a ref edge
    initial begin
        #3;
        forever begin
            meas_hp  = meas_period / 2;
            meas_clk = 1'b1;
            #(meas_hp);
            meas_clk = 1'b0;
            #(meas_hp);
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // per-cycle reference comparison of the return byte (R5 R6)
    always @(negedge ref_clk) begin
        if (model_on) begin
            total++;
            if (host_dout !== exp_dout) begin
                bad++;
                $display("FAIL R6 per-cycle model at %0t: actual=%02h expected=%02h",
                         $time, host_dout, exp_dout);
            end
        end
    end

    task automatic send(input logic [7:0] b, input logic [7:0] e, input string tag);
        @(negedge ref_clk);
        host_stb = 1'b1;
        host_din = b;
        @(posedge ref_clk);
        #1 exp_dout = e;
        @(negedge ref_clk);
        host_stb = 1'b0;
        check(host_dout, e, tag);
    endtask

    task automatic open_frame();
        @(negedge ref_clk);
        host_sel = 1'b1;
    endtask

    task automatic close_frame();
        @(negedge ref_clk);
        host_sel = 1'b0;
        @(posedge ref_clk);
        #1 exp_dout = 8'h00;
        @(negedge ref_clk);
        check(host_dout, 8'h00, "R10 dout after deselect");
    endtask

    task automatic read_count(input logic [31:0] v, input string tag);
        open_frame();
        send(8'hFE, 8'h00, tag);
        send(8'h00, v[31:24], tag);
        send(8'h00, v[23:16], tag);
        send(8'h00, v[15:8],  tag);
        send(8'h00, v[7:0],   tag);
        send(8'h00, 8'h00, "R8 byte after the fourth");
        close_frame();
    endtask

    initial begin
        repeat (20000) @(posedge ref_clk);
        bad++;
        total++;
        $display("FAIL R1 watchdog: cycles actual=20000 expected<20000");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        ref_rst_n  = 1'b0;
        meas_rst_n = 1'b0;
        host_sel   = 1'b0;
        host_stb   = 1'b0;
        host_din   = 8'h00;
        repeat (5) @(negedge ref_clk);
        ref_rst_n  = 1'b1;
        meas_rst_n = 1'b1;
        model_on   = 1'b1;
        check(host_dout, 8'h00, "R11 reset output");

        // R4: snapshot before the first gate completes
        read_count(32'd0, "R4 read before first gate");

        // R1 R5 R6: steady 2:1 ratio gives 2*GATE
        repeat (160) @(negedge ref_clk);
        read_count(32'd100, "R1 R5 count at 2:1 ratio");

        // R9: other opcode, no snapshot
        open_frame();
        send(8'h3A, 8'h00, "R9 other opcode");
        for (int i = 0; i < 5; i++) send(8'h00, 8'h00, "R9 no data on other opcode");
        close_frame();

        // R10: abort mid-read, next frame decodes an opcode again
        open_frame();
        send(8'hFE, 8'h00, "R10 opcode");
        send(8'h00, 8'h00, "R10 byte 3");
        send(8'h00, 8'h00, "R10 byte 2");
        send(8'h00, 8'h00, "R10 byte 1");
        close_frame();
        open_frame();
        send(8'hFE, 8'h00, "R10 first slot of new frame is opcode");
        send(8'h00, 8'h00, "R10 new frame byte 3");
        send(8'h00, 8'h00, "R10 new frame byte 2");
        send(8'h00, 8'h00, "R10 new frame byte 1");
        send(8'h00, 8'h64, "R10 new frame byte 0");
        close_frame();

        // R7: result changes while the frame holds a snapshot
        open_frame();
        send(8'hFE, 8'h00, "R7 opcode");
        send(8'h00, 8'h00, "R7 byte 3");
        meas_period = 8;
        repeat (200) @(negedge ref_clk);
        send(8'h00, 8'h00, "R7 byte 2 frozen");
        send(8'h00, 8'h00, "R7 byte 1 frozen");
        send(8'h00, 8'h64, "R7 byte 0 frozen");
        close_frame();

        // R2: new frequency reported; R3: repeated reads agree
        read_count(32'd125, "R2 count after frequency change");
        repeat (20) @(negedge ref_clk);
        read_count(32'd125, "R3 repeat read");

        model_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule